// File: doc/BRIEF.md
# Branch and Skip Condition Unit

This block works out where the program counter goes after a conditional relative branch or a conditional skip. A decode stage supplies the instruction class, the current PC, a signed word offset, the 8-bit status register, a 3-bit bit selector, two 8-bit operands, and a flag. The operands are register or I/O values. The flag tells whether the instruction that follows is two words long. One clock later the block returns the next PC, whether the condition held, and how many cycles the instruction costs.

There are two generic branch forms. One branches on a chosen status bit being set, the other on it being clear. Named conditions are these forms with a fixed bit: zero, carry, negative, half-carry, T, overflow and interrupt enable. The unsigned "same or higher" and "lower" tests are carry clear and carry set. The signed comparisons are separate classes that test N XOR V. Skips compare two operands for equality, or test one bit of a register or I/O value for clear or set. A taken skip jumps over the next instruction, so the distance and the cost both depend on that instruction's length.

Top module: `bsu_top`

## Requirements
- R1: A request sampled with `valid_i` high gives `valid_o` high on the next clock edge. A cycle sampled with `valid_i` low gives `valid_o` low. Results are registered one cycle after their request.
- R2: While `rst_ni` is low, `valid_o`, `taken_o`, `next_pc_o` and `cycles_o` are all zero.
- R3: Class 0 (branch if set) is taken when `sreg_i[bit_sel_i]` is 1. Status bit order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R4: Class 1 (branch if clear) is taken when `sreg_i[bit_sel_i]` is 0. Carry-clear (bit 0 clear) gives unsigned same-or-higher.
- R5: A taken branch gives `next_pc_o` = PC + sign-extended `ofs_i` + 1, modulo 2^PC_W, and `cycles_o` = 2.
- R6: Any request that is not taken gives `next_pc_o` = PC + 1 and `cycles_o` = 1.
- R7: Class 7 (signed greater-or-equal) is taken when `sreg_i[2]` XOR `sreg_i[3]` is 0. Class 8 (signed less-than) is taken when it is 1. The S bit (bit 4) and `bit_sel_i` have no effect on either class.
- R8: Class 2 (skip if equal) is taken when `opnd_a_i` equals `opnd_b_i`.
- R9: Classes 3 and 5 (register bit clear, I/O bit clear) are taken when `opnd_a_i[bit_sel_i]` is 0. Classes 4 and 6 (register bit set, I/O bit set) are taken when it is 1.
- R10: A taken skip advances the PC by 3 and costs 3 cycles when `two_word_i` is 1. Otherwise it advances by 2 and costs 2 cycles. `ofs_i` has no effect on skips.
- R11: Class codes 9 to 15 are never taken. They give PC + 1 and 1 cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| op_i | input | 4 | Instruction class code |
| pc_i | input | PC_W | Current program counter |
| ofs_i | input | OFS_W | Signed relative branch offset |
| sreg_i | input | 8 | Status register |
| bit_sel_i | input | 3 | Bit selector for status or operand bit |
| opnd_a_i | input | 8 | Tested register or I/O value |
| opnd_b_i | input | 8 | Second register for equality skip |
| two_word_i | input | 1 | Next instruction is two words long |
| valid_o | output | 1 | Result present |
| next_pc_o | output | PC_W | Next program counter |
| taken_o | output | 1 | Condition held |
| cycles_o | output | 2 | Cycles the instruction costs |

## Verification
Every result is due exactly one rising edge after the request was sampled. The unit has one register stage and no back-pressure, so requests can go in on consecutive cycles and results come out in the same order. The driver applies each request on a falling edge and queues the expected outcome. The monitor compares at the next falling edge, which falls half a period after the result register loads, and pops one entry for each cycle that `valid_o` is high. A result that arrives early, late or out of order therefore lines up with the wrong entry and is reported.

// File: rtl/bsu_pkg.sv
`timescale 1ns/1ps
package bsu_pkg;
  localparam logic [3:0] OP_BR_SET  = 4'd0;
  localparam logic [3:0] OP_BR_CLR  = 4'd1;
  localparam logic [3:0] OP_SK_EQ   = 4'd2;
  localparam logic [3:0] OP_SK_RCLR = 4'd3;
  localparam logic [3:0] OP_SK_RSET = 4'd4;
  localparam logic [3:0] OP_SK_ICLR = 4'd5;
  localparam logic [3:0] OP_SK_ISET = 4'd6;
  localparam logic [3:0] OP_BR_SGE  = 4'd7;
  localparam logic [3:0] OP_BR_SLT  = 4'd8;

  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_V = 3;

  typedef struct packed {
    logic take;
    logic is_br;
    logic is_skip;
  } cond_t;
endpackage

// File: rtl/bsu_cond.sv
`timescale 1ns/1ps
module bsu_cond
  import bsu_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic [7:0] sreg_i,
  input  logic [2:0] bit_sel_i,
  input  logic [7:0] opnd_a_i,
  input  logic [7:0] opnd_b_i,
  output cond_t      cond_o
);
  logic sbit, obit, sgn_lt;

  assign sbit   = sreg_i[bit_sel_i];
  assign obit   = opnd_a_i[bit_sel_i];
  assign sgn_lt = sreg_i[FLAG_N] ^ sreg_i[FLAG_V];

  always_comb begin
    cond_o = '0;
    case (op_i)
      OP_BR_SET:  begin cond_o.is_br = 1'b1;   cond_o.take = sbit;    end
      OP_BR_CLR:  begin cond_o.is_br = 1'b1;   cond_o.take = ~sbit;   end
      OP_BR_SGE:  begin cond_o.is_br = 1'b1;   cond_o.take = ~sgn_lt; end
      OP_BR_SLT:  begin cond_o.is_br = 1'b1;   cond_o.take = sgn_lt;  end
      OP_SK_EQ:   begin cond_o.is_skip = 1'b1; cond_o.take = (opnd_a_i == opnd_b_i); end
      OP_SK_RCLR,
      OP_SK_ICLR: begin cond_o.is_skip = 1'b1; cond_o.take = ~obit;   end
      OP_SK_RSET,
      OP_SK_ISET: begin cond_o.is_skip = 1'b1; cond_o.take = obit;    end
      default:    cond_o = '0;
    endcase
  end
endmodule

// File: rtl/bsu_next.sv
`timescale 1ns/1ps
module bsu_next
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 7
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  cond_t            cond_i,
  input  logic             two_word_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic [1:0]       cycles_o
);
  logic [PC_W-1:0] ofs_ext;

  generate
    if (OFS_W < PC_W) begin : g_sext
      assign ofs_ext = {{(PC_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
    end else begin : g_trunc
      assign ofs_ext = ofs_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    next_pc_o = pc_i + PC_W'(1);
    cycles_o  = 2'd1;
    if (cond_i.take && cond_i.is_br) begin
      next_pc_o = pc_i + ofs_ext + PC_W'(1);
      cycles_o  = 2'd2;
    end else if (cond_i.take && cond_i.is_skip) begin
      if (two_word_i) begin
        next_pc_o = pc_i + PC_W'(3);
        cycles_o  = 2'd3;
      end else begin
        next_pc_o = pc_i + PC_W'(2);
        cycles_o  = 2'd2;
      end
    end
  end
endmodule

// File: rtl/bsu_top.sv
`timescale 1ns/1ps
module bsu_top
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [7:0]       sreg_i,
  input  logic [2:0]       bit_sel_i,
  input  logic [7:0]       opnd_a_i,
  input  logic [7:0]       opnd_b_i,
  input  logic             two_word_i,
  output logic             valid_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             taken_o,
  output logic [1:0]       cycles_o
);
  cond_t           cond;
  logic [PC_W-1:0] npc;
  logic [1:0]      cyc;

  bsu_cond u_cond (
    .op_i      (op_i),
    .sreg_i    (sreg_i),
    .bit_sel_i (bit_sel_i),
    .opnd_a_i  (opnd_a_i),
    .opnd_b_i  (opnd_b_i),
    .cond_o    (cond)
  );

  bsu_next #(.PC_W(PC_W), .OFS_W(OFS_W)) u_next (
    .pc_i       (pc_i),
    .ofs_i      (ofs_i),
    .cond_i     (cond),
    .two_word_i (two_word_i),
    .next_pc_o  (npc),
    .cycles_o   (cyc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      next_pc_o <= '0;
      taken_o   <= 1'b0;
      cycles_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        next_pc_o <= npc;
        taken_o   <= cond.take;
        cycles_o  <= cyc;
      end
    end
  end
endmodule

// File: rtl/bsu_chk.sv
`timescale 1ns/1ps
module bsu_chk
  import bsu_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [3:0]       op_i,
  input logic [PC_W-1:0]  pc_i,
  input logic [7:0]       sreg_i,
  input logic             two_word_i,
  input logic             valid_o,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             taken_o,
  input logic [1:0]       cycles_o
);
  logic in_br, in_skip;
  assign in_br   = (op_i == OP_BR_SET) || (op_i == OP_BR_CLR) ||
                   (op_i == OP_BR_SGE) || (op_i == OP_BR_SLT);
  assign in_skip = (op_i >= OP_SK_EQ) && (op_i <= OP_SK_ISET);

  assert_valid_lat_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (valid_o == $past(valid_i)));

  assert_branch_cost_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o && $past(in_br)) |-> (cycles_o == 2'd2));

  assert_not_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |->
      ((next_pc_o == $past(pc_i) + PC_W'(1)) && (cycles_o == 2'd1)));

  assert_signed_ge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) == OP_BR_SGE) |->
      (taken_o == ($past(sreg_i[FLAG_N]) == $past(sreg_i[FLAG_V]))));

  assert_skip_dist_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o && $past(in_skip)) |->
      ((cycles_o == ($past(two_word_i) ? 2'd3 : 2'd2)) &&
       (next_pc_o == $past(pc_i) + PC_W'(cycles_o))));

  assert_undef_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(op_i) > OP_BR_SLT) |-> !taken_o);
endmodule

bind bsu_top bsu_chk #(.PC_W(PC_W), .OFS_W(OFS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .pc_i       (pc_i),
  .sreg_i     (sreg_i),
  .two_word_i (two_word_i),
  .valid_o    (valid_o),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .cycles_o   (cycles_o)
);

// File: tb/bsu_top_tb_top.sv
`timescale 1ns/1ps
module bsu_top_tb_top;
  localparam int unsigned PC_W  = 16;
  localparam int unsigned OFS_W = 7;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [3:0]       op_i = '0;
  logic [PC_W-1:0]  pc_i = '0;
  logic [OFS_W-1:0] ofs_i = '0;
  logic [7:0]       sreg_i = '0;
  logic [2:0]       bit_sel_i = '0;
  logic [7:0]       opnd_a_i = '0;
  logic [7:0]       opnd_b_i = '0;
  logic             two_word_i = 1'b0;
  logic             valid_o;
  logic [PC_W-1:0]  next_pc_o;
  logic             taken_o;
  logic [1:0]       cycles_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [PC_W-1:0] pc;
    logic            tk;
    logic [1:0]      cyc;
    string           tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  bsu_top #(.PC_W(PC_W), .OFS_W(OFS_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .pc_i(pc_i), .ofs_i(ofs_i), .sreg_i(sreg_i), .bit_sel_i(bit_sel_i),
    .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .two_word_i(two_word_i),
    .valid_o(valid_o), .next_pc_o(next_pc_o), .taken_o(taken_o),
    .cycles_o(cycles_o)
  );

  task automatic drive(input logic [3:0] op, input logic [15:0] pc,
                       input logic [6:0] ofs, input logic [7:0] sreg,
                       input logic [2:0] sel, input logic [7:0] a,
                       input logic [7:0] b, input logic tw,
                       input logic [15:0] e_pc, input logic e_tk,
                       input logic [1:0] e_cyc, input string tag);
    exp_t e;
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; pc_i = pc; ofs_i = ofs; sreg_i = sreg;
    bit_sel_i = sel; opnd_a_i = a; opnd_b_i = b; two_word_i = tw;
    e.pc = e_pc; e.tk = e_tk; e.cyc = e_cyc; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare each produced result with the oldest queued expectation
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      exp_t e;
      n_cmp++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1 unexpected result: actual pc=%h, expected none", next_pc_o);
      end else begin
        e = sb_q.pop_front();
        if (next_pc_o !== e.pc || taken_o !== e.tk || cycles_o !== e.cyc) begin
          n_bad++;
          $display("FAIL %s: actual pc=%h tk=%b cyc=%0d, expected pc=%h tk=%b cyc=%0d",
                   e.tag, next_pc_o, taken_o, cycles_o, e.pc, e.tk, e.cyc);
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R2: reset state
    n_cmp++;
    if (valid_o !== 1'b0 || next_pc_o !== '0 || taken_o !== 1'b0 || cycles_o !== 2'd0) begin
      n_bad++;
      $display("FAIL R2 reset: actual v=%b pc=%h tk=%b cyc=%0d, expected all zero",
               valid_o, next_pc_o, taken_o, cycles_o);
    end
    rst_ni = 1'b1;

    // branch if set / clear, back to back
    drive(4'd0, 16'h0100, 7'd5,   8'h02, 3'd1, 8'h00, 8'h00, 1'b0, 16'h0106, 1'b1, 2'd2, "R3 R5 zero set taken");
    drive(4'd0, 16'h0100, 7'd5,   8'hFD, 3'd1, 8'h00, 8'h00, 1'b0, 16'h0101, 1'b0, 2'd1, "R3 R6 zero set not taken");
    drive(4'd1, 16'h0200, 7'h7D,  8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 16'h01FE, 1'b1, 2'd2, "R4 R5 carry clear negative ofs");
    drive(4'd1, 16'h0200, 7'h7D,  8'h01, 3'd0, 8'h00, 8'h00, 1'b0, 16'h0201, 1'b0, 2'd1, "R4 R6 carry set not taken");
    drive(4'd0, 16'hFFFE, 7'd3,   8'h80, 3'd7, 8'h00, 8'h00, 1'b1, 16'h0002, 1'b1, 2'd2, "R5 wrap around");
    drive(4'd0, 16'h1000, 7'h40,  8'h40, 3'd6, 8'h00, 8'h00, 1'b0, 16'h0FC1, 1'b1, 2'd2, "R5 most negative ofs");
    // signed compares: S bit and selector must not matter
    drive(4'd7, 16'h0300, 7'd2,   8'h0C, 3'd4, 8'h00, 8'h00, 1'b0, 16'h0303, 1'b1, 2'd2, "R7 ge N=V=1");
    drive(4'd7, 16'h0300, 7'd2,   8'h14, 3'd4, 8'h00, 8'h00, 1'b0, 16'h0301, 1'b0, 2'd1, "R7 ge N=1 V=0 S=1");
    drive(4'd8, 16'h0300, 7'd2,   8'h04, 3'd4, 8'h00, 8'h00, 1'b0, 16'h0303, 1'b1, 2'd2, "R7 lt N=1 V=0 S=0");
    drive(4'd8, 16'h0300, 7'd2,   8'h1C, 3'd2, 8'h00, 8'h00, 1'b0, 16'h0301, 1'b0, 2'd1, "R7 lt N=V=1 S=1");
    // skips
    drive(4'd2, 16'h0400, 7'h3F,  8'h00, 3'd0, 8'h5A, 8'h5A, 1'b0, 16'h0402, 1'b1, 2'd2, "R8 R10 equal one word");
    drive(4'd2, 16'h0400, 7'h3F,  8'hFF, 3'd0, 8'h5A, 8'h5B, 1'b1, 16'h0401, 1'b0, 2'd1, "R8 R6 not equal");
    drive(4'd3, 16'h0400, 7'd9,   8'h00, 3'd3, 8'hF7, 8'h00, 1'b1, 16'h0403, 1'b1, 2'd3, "R9 R10 reg bit clear two words");
    drive(4'd4, 16'h0400, 7'd9,   8'h00, 3'd3, 8'hF7, 8'h00, 1'b1, 16'h0401, 1'b0, 2'd1, "R9 reg bit set not taken");
    drive(4'd6, 16'hFFFE, 7'd9,   8'h00, 3'd0, 8'h01, 8'h00, 1'b1, 16'h0001, 1'b1, 2'd3, "R9 R10 io bit set wrap");
    drive(4'd5, 16'h0400, 7'd9,   8'h00, 3'd0, 8'h01, 8'h00, 1'b0, 16'h0401, 1'b0, 2'd1, "R9 io bit clear not taken");
    drive(4'd5, 16'h0400, 7'h7F,  8'h00, 3'd7, 8'h00, 8'h00, 1'b0, 16'h0402, 1'b1, 2'd2, "R9 R10 io bit clear one word");
    // undefined classes
    drive(4'hF, 16'h0500, 7'd9,   8'hFF, 3'd0, 8'h11, 8'h11, 1'b1, 16'h0501, 1'b0, 2'd1, "R11 code 15");
    drive(4'h9, 16'h0500, 7'd9,   8'hFF, 3'd0, 8'h11, 8'h11, 1'b1, 16'h0501, 1'b0, 2'd1, "R11 code 9");

    @(negedge clk_i);
    valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    // R1: idle cycle yields no result, and all queued results arrived
    n_cmp++;
    if (valid_o !== 1'b0 || sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 idle: actual v=%b pending=%0d, expected v=0 pending=0",
               valid_o, sb_q.size());
    end
    finish_run();
  end
endmodule